// File: doc/BRIEF.md
# Packet FIFO with Skid Margin and Errored-Packet Drop

This block sits between a packet source and a downstream consumer. The source presents 128-bit words, one per cycle. Each word is qualified by an enable and carries start-of-packet and end-of-packet flags. The end word also carries a count of empty trailing bytes and an error flag. The block stores accepted words in a packet FIFO and hands them on as a plain valid/ready stream. That stream carries the data, both packet flags and the empty count.

The ready output falls while there is still room for a fixed number of extra writes (the skid allowance, default four). A source that reacts late to ready therefore loses nothing. A source that goes past the allowance has broken the flow-control contract. Such extra words are thrown away, and a sticky overflow flag rises, which a dedicated clear input can lower.

A packet is held back until its end word arrives. If that end word carries the error flag, or if any word of the packet was thrown away, the whole packet is removed and none of its words reach the output. Removal is done by rewinding a speculative write pointer to the last committed packet boundary. The reader only ever sees committed packets.

Top module: `pkt_skid_fifo`

## Requirements
- R1: During and right after reset, in_rdy is 1, out_valid is 0 and ovf_flag is 0.
- R2: in_rdy is 1 exactly when the free entries are at least SKID+1. Free entries are DEPTH minus all stored words, counting the words of a packet whose end has not yet arrived.
- R3: After in_rdy falls, up to SKID words written while it stays low are stored, and ovf_flag does not rise.
- R4: A write with in_en=1 while in_rdy=0, after SKID words were already accepted since in_rdy fell, is a violation. ovf_flag is 1 from the next cycle, the word is discarded, and the packet in progress is dropped when its end word arrives. A violating end word ends and drops the packet itself.
- R5: ovf_flag stays 1 until a cycle with ovf_clr=1 and no new violation. In that case it is 0 from the next cycle. A violation in the same cycle as the clear keeps it at 1.
- R6: A packet whose accepted end word has in_err=1 is removed whole, and none of its words ever appear on the output. The empty count of that word is ignored.
- R7: No word of a packet appears on the output before the cycle after its end word is accepted without error.
- R8: A word leaves the output only in a cycle with out_valid=1 and out_ready=1. Words leave in the order they were written. While out_valid=1 and out_ready=0, the output holds its word.
- R9: out_sop and out_eop repeat the flags written with the word. out_mty equals in_mty on an end word (bits of in_mty: the count of empty bytes at the low end of the data) and is 0 on every other word.
- R10: In a cycle with in_en=0, every other write-side input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_en | input | 1 | Write qualifier for the write-side inputs |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_err | input | 1 | Packet in error; valid with in_eop |
| in_mty | input | 4 | Empty trailing byte count; valid with in_eop |
| in_data | input | 128 | Packet data, first byte in the top bits |
| in_rdy | output | 1 | Source may write |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| ovf_flag | output | 1 | Sticky flow-control violation flag |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer accepts the output word |
| out_sop | output | 1 | Output word starts a packet |
| out_eop | output | 1 | Output word ends a packet |
| out_mty | output | 4 | Empty byte count of the output end word |
| out_data | output | 128 | Output data |

## Verification
The bench builds the block with DEPTH=16 and SKID=4. At this depth the storage fills after twelve ready writes plus four skid writes, so the ready threshold, an exactly full FIFO and the first violating write are all reached within a few dozen cycles. The small depth also makes random phases with a stalled consumer hit overflow, packet rewind and recovery many times. Packets longer than the whole storage are part of the stimulus, which forces the drop of a packet that was still being written.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;

    localparam int DATA_W = 128;
    localparam int BYTES  = DATA_W / 8;
    localparam int MTY_W  = $clog2(BYTES);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sop;
        logic              eop;
        logic [MTY_W-1:0]  mty;
    } pkt_word_t;

    // The empty count only means something on an end word; store zero elsewhere.
    function automatic pkt_word_t make_word(logic [DATA_W-1:0] data, logic sop,
                                            logic eop, logic [MTY_W-1:0] mty);
        pkt_word_t w;
        w.data = data;
        w.sop  = sop;
        w.eop  = eop;
        w.mty  = eop ? mty : '0;
        return w;
    endfunction

endpackage

// File: rtl/pkt_fifo_mem.sv
module pkt_fifo_mem
    import pkt_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  pkt_word_t     wdata,
    input  logic [AW-1:0] raddr,
    output pkt_word_t     rdata
);

    pkt_word_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/pkt_fifo_wrctl.sv
module pkt_fifo_wrctl #(
    parameter int DEPTH = 32,
    parameter int SKID  = 4,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(SKID + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_en,
    input  logic          in_eop,
    input  logic          in_err,
    input  logic          ovf_clr,
    input  logic [AW:0]   rd_ptr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   com_ptr,
    output logic          in_rdy,
    output logic          ovf_flag,
    output logic [CW-1:0] skid_cnt
);

    logic [AW:0] spec_ptr;
    logic [AW:0] used;
    logic [AW:0] free;
    logic        bad;
    logic        viol;
    logic        accept;
    logic        drop_end;
    logic        good_end;

    assign used     = spec_ptr - rd_ptr;
    assign free     = (AW+1)'(DEPTH) - used;
    assign in_rdy   = free >= (AW+1)'(SKID + 1);
    assign viol     = in_en && !in_rdy && (skid_cnt >= CW'(SKID));
    assign accept   = in_en && !viol;
    assign drop_end = accept && in_eop && (in_err || bad);
    assign good_end = accept && in_eop && !in_err && !bad;
    assign we       = accept && !drop_end;
    assign waddr    = spec_ptr[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            spec_ptr <= '0;
            com_ptr  <= '0;
            bad      <= 1'b0;
        end else if (viol) begin
            if (in_eop) begin
                spec_ptr <= com_ptr;
                bad      <= 1'b0;
            end else begin
                bad      <= 1'b1;
            end
        end else if (drop_end) begin
            spec_ptr <= com_ptr;
            bad      <= 1'b0;
        end else if (we) begin
            spec_ptr <= spec_ptr + 1'b1;
            if (good_end) com_ptr <= spec_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ovf_flag <= 1'b0;
        else if (viol)    ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || in_rdy) skid_cnt <= '0;
        else if (accept)   skid_cnt <= skid_cnt + 1'b1;
    end

endmodule

// File: rtl/pkt_fifo_rdctl.sv
module pkt_fifo_rdctl #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [AW:0] com_ptr,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [AW:0] rd_ptr
);

    assign out_valid = rd_ptr != com_ptr;

    always_ff @(posedge clk) begin
        if (rst)                         rd_ptr <= '0;
        else if (out_valid && out_ready) rd_ptr <= rd_ptr + 1'b1;
    end

endmodule

// File: rtl/pkt_skid_fifo.sv
module pkt_skid_fifo
    import pkt_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int SKID  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_en,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_err,
    input  logic [MTY_W-1:0]  in_mty,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_rdy,
    input  logic              ovf_clr,
    output logic              ovf_flag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sop,
    output logic              out_eop,
    output logic [MTY_W-1:0]  out_mty,
    output logic [DATA_W-1:0] out_data
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(SKID + 1);

    logic [AW:0]   com_ptr;
    logic [AW:0]   rd_ptr;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [CW-1:0] wr_skid;
    pkt_word_t     wr_word;
    pkt_word_t     rd_word;

    assign wr_word = make_word(in_data, in_sop, in_eop, in_mty);

    pkt_fifo_wrctl #(.DEPTH(DEPTH), .SKID(SKID)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .in_en    (in_en),
        .in_eop   (in_eop),
        .in_err   (in_err),
        .ovf_clr  (ovf_clr),
        .rd_ptr   (rd_ptr),
        .we       (mem_we),
        .waddr    (mem_waddr),
        .com_ptr  (com_ptr),
        .in_rdy   (in_rdy),
        .ovf_flag (ovf_flag),
        .skid_cnt (wr_skid)
    );

    pkt_fifo_mem #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_word),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (rd_word)
    );

    pkt_fifo_rdctl #(.DEPTH(DEPTH)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .com_ptr   (com_ptr),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .rd_ptr    (rd_ptr)
    );

    assign out_data = rd_word.data;
    assign out_sop  = rd_word.sop;
    assign out_eop  = rd_word.eop;
    assign out_mty  = rd_word.mty;

endmodule

// File: rtl/pkt_skid_fifo_chk.sv
module pkt_skid_fifo_chk
    import pkt_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int SKID  = 4,
    parameter int CW    = $clog2(SKID + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              in_en,
    input logic              in_rdy,
    input logic              ovf_clr,
    input logic              ovf_flag,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_eop,
    input logic [MTY_W-1:0]  out_mty,
    input logic [DATA_W-1:0] out_data,
    input logic [CW-1:0]     wr_skid
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_rdy && !out_valid && !ovf_flag));

    // R4
    violation_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_en && !in_rdy && (wr_skid >= CW'(SKID))) |=> ovf_flag);

    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eop)));

    // R9
    mty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eop) |-> (out_mty == '0));

endmodule

bind pkt_skid_fifo pkt_skid_fifo_chk #(.DEPTH(DEPTH), .SKID(SKID)) u_chk (.*);

// File: tb/pkt_skid_fifo_bench.sv
module pkt_skid_fifo_bench;
    import pkt_fifo_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int SKID       = 4;
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_en, in_sop, in_eop, in_err, ovf_clr, out_ready;
    logic [MTY_W-1:0]  in_mty;
    logic [DATA_W-1:0] in_data;
    logic              in_rdy, ovf_flag, out_valid, out_sop, out_eop;
    logic [MTY_W-1:0]  out_mty;
    logic [DATA_W-1:0] out_data;

    pkt_skid_fifo #(.DEPTH(DEPTH), .SKID(SKID)) u_pkt_skid_fifo (
        .clk(clk), .rst(rst), .in_en(in_en), .in_sop(in_sop), .in_eop(in_eop),
        .in_err(in_err), .in_mty(in_mty), .in_data(in_data), .in_rdy(in_rdy),
        .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .out_valid(out_valid),
        .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop),
        .out_mty(out_mty), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // reference model state
    pkt_word_t mq[$];
    pkt_word_t pend[$];
    bit        m_bad  = 1'b0;
    int        m_cnt  = 0;
    bit        m_ovf  = 1'b0;

    // packet generator state
    int gen_len = 3;
    int gen_idx = 0;
    int writer_skid = 0;

    task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit model_rdy();
        return (DEPTH - mq.size() - pend.size()) >= SKID + 1;
    endfunction

    task automatic check_outputs();
        chk("R2 in_rdy", {127'd0, in_rdy}, {127'd0, model_rdy()});
        chk("R5 ovf_flag", {127'd0, ovf_flag}, {127'd0, m_ovf});
        chk("R7 out_valid", {127'd0, out_valid}, {127'd0, mq.size() > 0});
        if (mq.size() > 0 && out_valid) begin
            chk("R8 out_data", out_data, mq[0].data);
            chk("R9 out_sop", {127'd0, out_sop}, {127'd0, mq[0].sop});
            chk("R9 out_eop", {127'd0, out_eop}, {127'd0, mq[0].eop});
            chk("R9 out_mty", {124'd0, out_mty}, {124'd0, mq[0].mty});
        end
    endtask

    // Drive one cycle, advance the model, then check after the edge.
    task automatic step(bit en, bit ordy, bit clr, int err_pct);
        bit rdy, viol, pop;
        pkt_word_t w;
        in_data   = {$urandom, $urandom, $urandom, $urandom};
        in_mty    = MTY_W'($urandom);
        in_err    = 1'($urandom);
        in_sop    = 1'($urandom);
        in_eop    = 1'($urandom);
        in_en     = en;
        out_ready = ordy;
        ovf_clr   = clr;
        if (en) begin
            in_sop = (gen_idx == 0);
            in_eop = (gen_idx == gen_len - 1);
            in_err = in_eop && (($urandom % 100) < err_pct);
            if (!in_eop) in_mty = '0;
        end
        rdy  = model_rdy();
        viol = en && !rdy && (m_cnt >= SKID);
        pop  = (mq.size() > 0) && ordy;
        w    = make_word(in_data, in_sop, in_eop, in_mty);
        if (pop) void'(mq.pop_front());
        if (viol) begin
            if (in_eop) begin pend.delete(); m_bad = 1'b0; end
            else m_bad = 1'b1;
        end else if (en) begin
            if (in_eop && (in_err || m_bad)) begin
                pend.delete(); m_bad = 1'b0;
            end else begin
                pend.push_back(w);
                if (in_eop) begin
                    foreach (pend[i]) mq.push_back(pend[i]);
                    pend.delete();
                end
            end
        end
        if (viol) m_ovf = 1'b1;
        else if (clr) m_ovf = 1'b0;
        if (rdy) m_cnt = 0;
        else if (en && !viol) m_cnt++;
        if (en) begin
            if (gen_idx == gen_len - 1) begin
                gen_idx = 0;
                gen_len = 1 + int'($urandom % 7);
            end else gen_idx++;
        end
        @(posedge clk);
        @(negedge clk);
        check_outputs();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_en = 0; in_sop = 0; in_eop = 0; in_err = 0; in_mty = '0;
        in_data = '0; ovf_clr = 0; out_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 rdy in reset", {127'd0, in_rdy}, 128'd1);
        chk("R1 valid in reset", {127'd0, out_valid}, 128'd0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 rdy after reset", {127'd0, in_rdy}, 128'd1);
        chk("R1 valid after reset", {127'd0, out_valid}, 128'd0);
        chk("R1 ovf after reset", {127'd0, ovf_flag}, 128'd0);

        // R10: idle cycles with garbage on the other inputs
        repeat (5) step(1'b0, 1'b1, 1'b0, 0);
        chk("R10 nothing stored", {127'd0, out_valid}, 128'd0);

        // R6: lone errored packet never appears
        gen_len = 1; gen_idx = 0;
        step(1'b1, 1'b1, 1'b0, 100);
        step(1'b0, 1'b1, 1'b0, 0);
        chk("R6 errored packet dropped", {127'd0, out_valid}, 128'd0);

        // R3/R4: long packet fills the storage with a stalled consumer
        gen_len = 30; gen_idx = 0;
        while (in_rdy) step(1'b1, 1'b0, 1'b0, 0);
        for (int k = 0; k < SKID; k++) step(1'b1, 1'b0, 1'b0, 0);
        chk("R3 skid writes without overflow", {127'd0, ovf_flag}, 128'd0);
        chk("R3 storage full", {127'd0, in_rdy}, 128'd0);
        step(1'b1, 1'b0, 1'b0, 0);
        chk("R4 excess write flags overflow", {127'd0, ovf_flag}, 128'd1);
        while (gen_idx != 0) step(1'b1, 1'b0, 1'b0, 0);
        chk("R4 damaged packet dropped", {127'd0, out_valid}, 128'd0);
        chk("R4 space reclaimed", {127'd0, in_rdy}, 128'd1);
        step(1'b0, 1'b0, 1'b0, 0);
        chk("R5 flag held", {127'd0, ovf_flag}, 128'd1);
        step(1'b0, 1'b0, 1'b1, 0);
        chk("R5 flag cleared", {127'd0, ovf_flag}, 128'd0);

        // R7/R8: a good packet with stalled then running consumer
        gen_len = 3; gen_idx = 0;
        step(1'b1, 1'b0, 1'b0, 0);
        step(1'b1, 1'b0, 1'b0, 0);
        chk("R7 unfinished packet hidden", {127'd0, out_valid}, 128'd0);
        step(1'b1, 1'b0, 1'b0, 0);
        chk("R7 finished packet visible", {127'd0, out_valid}, 128'd1);
        repeat (4) step(1'b0, 1'b1, 1'b0, 0);

        // constrained random phases
        for (int ph = 0; ph < 30; ph++) begin
            int obey_pct = ($urandom % 2) ? 100 : 60;
            int en_pct   = 30 + int'($urandom % 70);
            int rd_pct   = int'($urandom % 101);
            for (int c = 0; c < 100; c++) begin
                bit want = (($urandom % 100) < en_pct);
                bit en;
                if (in_rdy) writer_skid = 0;
                en = want && (in_rdy || writer_skid < SKID || (($urandom % 100) >= obey_pct));
                if (en && !in_rdy) writer_skid++;
                step(en, (($urandom % 100) < rd_pct), (($urandom % 20) == 0), 20);
            end
        end
        repeat (DEPTH + 2) step(1'b0, 1'b1, 1'b0, 0);
        chk("R8 drained", {127'd0, out_valid}, 128'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule